// File: doc/BRIEF.md
# Vector Element Lane Steering Unit

This unit moves one scalar element between a 16-byte memory line and a single lane of a 128-bit vector register. It serves element loads and element stores for byte, halfword and word sizes. From the low four bits of the effective address and the element size it derives the element index. In little-endian mode it does two things: it mirrors that index to the opposite end of the register, and it reverses the byte order of the element. It then inserts the element into the register image (load) or extracts it onto the store line with byte enables (store).

Register bytes are numbered from the most significant end. Register byte `k` sits on bits `[127-8k : 120-8k]`. Memory line byte `k`, the byte at line offset `k`, uses the same bit position on `mem_rdata` and `st_data` and is enabled by `st_be[k]`. All results are registered. They appear one cycle after an input strobe, together with `out_valid`.

Top module: `vec_lane_steer`

## Requirements
- R1: The element size code is 0 for byte, 1 for halfword and 2 for word; code 3 acts as word. The element width is n = 1, 2 or 4 bytes. The element offset is `off = (ea_low >> log2 n) << log2 n`, so address bits below the element size are ignored and a misaligned address rounds down.
- R2: In big-endian mode (`little_end`=0) the element takes register bytes `off .. off+n-1`. On a load, register byte `off+j` receives memory line byte `off+j`.
- R3: In little-endian mode the lane index is mirrored, so the element takes register bytes starting at `16 - n - off`. This equals index (16/n - 1 - off/n) times n.
- R4: In little-endian mode the element's bytes are reversed on the way through. On a load, register byte `base+j` receives memory line byte `off+n-1-j`. A byte element is moved unchanged apart from the mirroring.
- R5: On a load, every register byte outside the addressed element keeps its value from `vreg_in`.
- R6: On a store, `st_be` has bits `off .. off+n-1` set and no others. `st_data` carries the element on those line bytes and zero on every other byte.
- R7: On a store, the register bytes are picked with the same mirroring and reversal as on a load. In big-endian mode line byte `off+j` receives register byte `off+j`. In little-endian mode it receives register byte `16-n-off + n-1-j`.
- R8: After reset all outputs are zero. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the results of that input are visible in the same cycle.
- R9: On a load, `st_be` and `st_data` are zero. On a store, `vreg_out` equals the `vreg_in` that was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_is_store | input | 1 | 1 = store element, 0 = load element |
| ea_low | input | 4 | Low effective-address bits |
| elem_size | input | 2 | Element size code (R1) |
| little_end | input | 1 | 1 = little-endian mode |
| mem_rdata | input | 128 | Memory line read for a load |
| vreg_in | input | 128 | Current vector register value |
| out_valid | output | 1 | Results valid |
| vreg_out | output | 128 | Updated vector register value |
| st_data | output | 128 | Store line data |
| st_be | output | 16 | Store byte enables, bit k for line byte k |

## Verification
In little-endian mode, lane mirroring and byte reversal act on the same element in the same cycle. A fault in either one, or in the order they are applied, moves or scrambles the element in a way that one of them alone would not. The bench sweeps every address offset, size and mode for both loads and stores. Memory and register patterns have a distinct value in every byte, so a misplaced or reversed byte is detected. The expected element is built arithmetically as an integer value and compared lane by lane.

// File: rtl/vls_pkg.sv
package vls_pkg;

    localparam int unsigned LINE_BYTES = 16;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
    localparam int unsigned LINE_W     = LINE_BYTES * BYTE_W;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'd0,
        ESZ_HALF = 2'd1,
        ESZ_WORD = 2'd2,
        ESZ_RSVD = 2'd3
    } esize_e;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } vop_e;

    // Placement of one element: memory offset, register base byte, width, swap
    typedef struct packed {
        logic [OFF_W-1:0] off;
        logic [OFF_W-1:0] base;
        logic [OFF_W:0]   nbytes;
        logic             swap;
    } steer_t;

    function automatic logic [1:0] size_log2(input esize_e s);
        return (s == ESZ_RSVD) ? 2'd2 : 2'(s);
    endfunction

    function automatic logic [BYTE_W-1:0] line_byte(input logic [LINE_W-1:0] v, input int k);
        return v[LINE_W-1-BYTE_W*k -: BYTE_W];
    endfunction

endpackage

// File: rtl/vls_lane_calc.sv
module vls_lane_calc
    import vls_pkg::*;
(
    input  logic [OFF_W-1:0] ea_low,
    input  esize_e           sz,
    input  logic             le,
    output steer_t           st
);
    logic [1:0]     lg;
    logic [OFF_W:0] n;
    logic [OFF_W:0] off_w;
    logic [OFF_W:0] base_w;

    always_comb begin
        lg     = size_log2(sz);
        n      = (OFF_W+1)'(1) << lg;
        off_w  = {1'b0, (ea_low >> lg) << lg};
        base_w = le ? ((OFF_W+1)'(LINE_BYTES) - n - off_w) : off_w;
        st.off    = off_w[OFF_W-1:0];
        st.base   = base_w[OFF_W-1:0];
        st.nbytes = n;
        st.swap   = le && (lg != 2'd0);
    end

    // R1/R3: the lane start is aligned to the element and the element fits the line
    always_comb begin
        a_base_aligned_r1: assert ((base_w & (n - 1'b1)) == '0);
        a_base_fits_r3:    assert ((base_w + n) <= (OFF_W+1)'(LINE_BYTES));
    end

endmodule

// File: rtl/vls_load_merge.sv
module vls_load_merge
    import vls_pkg::*;
(
    input  steer_t            st,
    input  logic [LINE_W-1:0] mem_line,
    input  logic [LINE_W-1:0] vreg_in,
    output logic [LINE_W-1:0] vreg_new
);
    for (genvar L = 0; L < LINE_BYTES; L++) begin : g_lane
        int   rel;
        int   src;
        logic hit;
        always_comb begin
            rel = L - int'(st.base);
            hit = (rel >= 0) && (rel < int'(st.nbytes));
            src = st.swap ? (int'(st.off) + int'(st.nbytes) - 1 - rel)
                          : (int'(st.off) + rel);
            if (hit)
                vreg_new[LINE_W-1-BYTE_W*L -: BYTE_W] = line_byte(mem_line, src);
            else
                vreg_new[LINE_W-1-BYTE_W*L -: BYTE_W] = line_byte(vreg_in, L);
        end
    end

endmodule

// File: rtl/vls_store_pick.sv
module vls_store_pick
    import vls_pkg::*;
(
    input  steer_t              st,
    input  logic [LINE_W-1:0]   vreg,
    output logic [LINE_W-1:0]   line_data,
    output logic [LINE_BYTES-1:0] line_be
);
    for (genvar K = 0; K < LINE_BYTES; K++) begin : g_byte
        int   rel;
        int   lane;
        logic hit;
        always_comb begin
            rel  = K - int'(st.off);
            hit  = (rel >= 0) && (rel < int'(st.nbytes));
            lane = st.swap ? (int'(st.base) + int'(st.nbytes) - 1 - rel)
                           : (int'(st.base) + rel);
            line_be[K] = hit;
            if (hit)
                line_data[LINE_W-1-BYTE_W*K -: BYTE_W] = line_byte(vreg, lane);
            else
                line_data[LINE_W-1-BYTE_W*K -: BYTE_W] = '0;
        end
    end

endmodule

// File: rtl/vec_lane_steer.sv
module vec_lane_steer
    import vls_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          op_is_store,
    input  logic [3:0]    ea_low,
    input  logic [1:0]    elem_size,
    input  logic          little_end,
    input  logic [127:0]  mem_rdata,
    input  logic [127:0]  vreg_in,
    output logic          out_valid,
    output logic [127:0]  vreg_out,
    output logic [127:0]  st_data,
    output logic [15:0]   st_be
);
    steer_t              st;
    vop_e                op;
    logic [LINE_W-1:0]   ld_vreg;
    logic [LINE_W-1:0]   sd_line;
    logic [LINE_BYTES-1:0] sd_be;

    assign op = vop_e'(op_is_store);

    vls_lane_calc u_calc (
        .ea_low (ea_low),
        .sz     (esize_e'(elem_size)),
        .le     (little_end),
        .st     (st)
    );

    vls_load_merge u_load (
        .st       (st),
        .mem_line (mem_rdata),
        .vreg_in  (vreg_in),
        .vreg_new (ld_vreg)
    );

    vls_store_pick u_store (
        .st        (st),
        .vreg      (vreg_in),
        .line_data (sd_line),
        .line_be   (sd_be)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            vreg_out  <= '0;
            st_data   <= '0;
            st_be     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                if (op == OP_STORE) begin
                    vreg_out <= vreg_in;
                    st_data  <= sd_line;
                    st_be    <= sd_be;
                end else begin
                    vreg_out <= ld_vreg;
                    st_data  <= '0;
                    st_be    <= '0;
                end
            end
        end
    end

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_be_width_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_is_store) |=>
            ($countones(st_be) == (32'd1 << size_log2(esize_e'($past(elem_size))))));
    p_load_no_be_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_is_store) |=> (st_be == '0));
    p_store_keeps_reg_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_is_store) |=> (vreg_out == $past(vreg_in)));

endmodule

// File: tb/vec_lane_steer_tb_top.sv
module vec_lane_steer_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, op_is_store, little_end;
    logic [3:0]   ea_low;
    logic [1:0]   elem_size;
    logic [127:0] mem_rdata, vreg_in;
    logic         out_valid;
    logic [127:0] vreg_out, st_data;
    logic [15:0]  st_be;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    vec_lane_steer dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_is_store(op_is_store),
        .ea_low(ea_low), .elem_size(elem_size), .little_end(little_end),
        .mem_rdata(mem_rdata), .vreg_in(vreg_in), .out_valid(out_valid),
        .vreg_out(vreg_out), .st_data(st_data), .st_be(st_be)
    );

    function automatic logic [7:0] byte_of(input logic [127:0] v, input int k);
        return 8'((v >> (8 * (15 - k))) & 128'hFF);
    endfunction

    task automatic check(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input bit store, input int ea, input int sz, input bit le,
                           input logic [127:0] mem, input logic [127:0] vr);
        int n, off, base;
        logic [31:0]  elem;
        logic [127:0] exp_vreg, exp_data, elem_mask;
        logic [15:0]  exp_be;
        string tag;
        n    = (sz >= 2) ? 4 : (1 << sz);
        off  = (ea / n) * n;
        base = le ? (16 / n - 1 - off / n) * n : off;
        elem = '0;
        exp_vreg = vr; exp_data = '0; exp_be = '0; elem_mask = '0;
        if (!store) begin
            // element value as read from memory in the selected byte order
            for (int t = 0; t < n; t++)
                if (le) elem |= 32'(byte_of(mem, off + t)) << (8 * t);
                else    elem |= 32'(byte_of(mem, off + t)) << (8 * (n - 1 - t));
            for (int j = 0; j < n; j++) begin
                exp_vreg &= ~(128'hFF << (8 * (15 - base - j)));
                exp_vreg |= 128'(8'(elem >> (8 * (n - 1 - j)))) << (8 * (15 - base - j));
                elem_mask |= 128'hFF << (8 * (15 - base - j));
            end
        end else begin
            // element value as held in the register (most significant byte first)
            for (int j = 0; j < n; j++)
                elem |= 32'(byte_of(vr, base + j)) << (8 * (n - 1 - j));
            for (int t = 0; t < n; t++) begin
                exp_be[off + t] = 1'b1;
                if (le) exp_data |= 128'(8'(elem >> (8 * t))) << (8 * (15 - off - t));
                else    exp_data |= 128'(8'(elem >> (8 * (n - 1 - t)))) << (8 * (15 - off - t));
            end
        end
        @(negedge clk);
        in_valid = 1'b1; op_is_store = store; ea_low = 4'(ea);
        elem_size = 2'(sz); little_end = le; mem_rdata = mem; vreg_in = vr;
        @(negedge clk);
        in_valid = 1'b0;
        tag = (ea % n != 0) ? "R1" : (le ? (n > 1 ? "R4" : "R3") : "R2");
        check("R8", "out_valid", 128'(out_valid), 128'd1);
        if (!store) begin
            check(tag, "load element lanes", vreg_out & elem_mask, exp_vreg & elem_mask);
            check("R5", "load other lanes", vreg_out & ~elem_mask, vr & ~elem_mask);
            check("R9", "load store-side zero", {st_data[127:16], st_data[15:0] | st_be}, 128'd0);
        end else begin
            check("R6", "store byte enables", 128'(st_be), 128'(exp_be));
            check(le ? "R7" : tag, "store data", st_data, exp_data);
            check("R9", "store keeps register", vreg_out, vr);
        end
    endtask

    initial begin
        logic [127:0] mem_a, mem_b, reg_a, reg_b;
        rst = 1'b1; in_valid = 1'b0; op_is_store = 1'b0; ea_low = '0;
        elem_size = '0; little_end = 1'b0; mem_rdata = '0; vreg_in = '0;
        mem_a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        mem_b = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
        reg_a = 128'hA0A1A2A3_A4A5A6A7_A8A9AAAB_ACADAEAF;
        reg_b = 128'h5F4E3D2C_1B0A9988_77665544_33221100;
        repeat (3) @(negedge clk);
        check("R8", "reset out_valid", 128'(out_valid), 128'd0);
        check("R8", "reset vreg_out", vreg_out, 128'd0);
        check("R8", "reset st_be/st_data", st_data | 128'(st_be), 128'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R8", "idle out_valid", 128'(out_valid), 128'd0);
        for (int le = 0; le < 2; le++)
            for (int sz = 0; sz < 4; sz++)
                for (int ea = 0; ea < 16; ea++) begin
                    run_one(1'b0, ea, sz, le[0], mem_a, reg_a);
                    run_one(1'b1, ea, sz, le[0], mem_b, reg_b);
                    run_one(1'b0, ea, sz, le[0], mem_b, reg_b);
                    run_one(1'b1, ea, sz, le[0], mem_a, reg_a);
                end
        @(negedge clk);
        check("R8", "out_valid drops after strobe", 128'(out_valid), 128'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL R8 watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule